// File: doc/BRIEF.md
# Bulk Endpoint Token Response Controller

This block chooses the answer that a bulk or interrupt device endpoint gives to each token the host sends. It keeps the endpoint's condition in a small state machine. Pulses from the rest of the controller move it between conditions: arm the endpoint, halt it, release the halt, report that transmit data ran dry, or report that receive space ran out. Each token strobe produces one response code one clock later. The code tells the packet engine to stay silent, send a handshake, take in data, send data, or corrupt an outgoing packet on purpose with a bit-stuff violation.

The condition states are `COND_IDLE` (not armed), `COND_PRIMED` (armed), `COND_UNDERRUN` (transmit data missing), `COND_OVERRUN` (receive space missing) and `COND_HALTED` (stalled).

The transitions are:
- **halt**: any state goes to `COND_HALTED` on `stall_i`.
- **release**: `COND_HALTED` goes to `COND_IDLE` on `unstall_i`.
- **arm**: `COND_IDLE` goes to `COND_PRIMED` on `prime_i`.
- **finish**: `COND_PRIMED` goes to `COND_IDLE` on an IN or OUT token when `pkts_left_i` is 0.
- **starve**: `COND_PRIMED` goes to `COND_UNDERRUN` on `underflow_i`.
- **flood**: `COND_PRIMED` goes to `COND_OVERRUN` on `overflow_i`.
- **report-starve**: `COND_UNDERRUN` goes back to `COND_PRIMED` after an IN token.
- **report-flood**: `COND_OVERRUN` goes back to `COND_PRIMED` after an OUT token.

Top module: `ep_token_responder`

## Requirements

Token kinds on `tok_kind_i` are encoded as 0 = SETUP, 1 = PING, 2 = OUT and 3 = IN; the values 4 to 7 are invalid. Response codes on `resp_code_o` are encoded as 0 = ignore, 1 = STALL, 2 = NAK, 3 = ACK, 4 = receive then ACK, 5 = receive then NYET, 6 = transmit and 7 = force bit-stuff error.

- R1: In `COND_HALTED`, PING, OUT and IN tokens are answered with code 1 (STALL).
- R2: A SETUP token (kind 0) is answered with code 0 in every condition, and it changes no condition.
- R3: A token of kind 4 to 7 is answered with code 0 in every condition, and it changes no condition.
- R4: In `COND_IDLE`, PING, OUT and IN tokens are answered with code 2 (NAK).
- R5: In `COND_PRIMED`:
  - PING is answered with code 3.
  - IN is answered with code 6.
  - OUT is answered with code 4 when `pkts_left_i` is 1.
- R6: In `COND_PRIMED`, an OUT token with `pkts_left_i` = 0 is answered with code 5. An OUT or IN token with `pkts_left_i` = 0 returns the endpoint to `COND_IDLE`. With `pkts_left_i` = 1 the endpoint stays primed.
- R7: In `COND_UNDERRUN`:
  - An IN token is answered with code 7 and the endpoint returns to `COND_PRIMED`.
  - PING and OUT tokens are answered with code 2 and the condition is kept.
- R8: In `COND_OVERRUN`:
  - An OUT token is answered with code 2 and the endpoint returns to `COND_PRIMED`.
  - PING and IN tokens are answered with code 2 and the condition is kept.
- R9: `stall_i` enters `COND_HALTED` from any condition. It wins over `unstall_i` in the same cycle. Only `unstall_i` leaves `COND_HALTED`, and it goes to `COND_IDLE`.
- R10: After reset:
  - The endpoint is in `COND_IDLE` and `resp_valid_o` is 0.
  - `resp_valid_o` is high for exactly the cycle after each token strobe and low otherwise.
- R11: `prime_i` has no effect outside `COND_IDLE`. `underflow_i` and `overflow_i` have no effect outside `COND_PRIMED`.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| prime_i | input | 1 | Arm the endpoint |
| stall_i | input | 1 | Halt the endpoint |
| unstall_i | input | 1 | Release the halt |
| underflow_i | input | 1 | Transmit data ran dry |
| overflow_i | input | 1 | Receive space ran out |
| tok_valid_i | input | 1 | Token strobe |
| tok_kind_i | input | 3 | Token kind |
| pkts_left_i | input | 1 | Descriptor has packets remaining |
| resp_valid_o | output | 1 | Response strobe, one cycle after the token |
| resp_code_o | output | 3 | Response code |

## Verification

A wrong condition register shows on the very next token as a wrong response code. The bench therefore follows each stimulus token with a second token whose answer tells the conditions apart. Halted gives STALL, underrun gives a forced bit-stuff error, and primed gives transmit or receive-ACK. A condition that fails to clear after a one-shot report, or one that leaks out of the halt, is therefore exposed within two tokens. Ignored tokens and ignored events are followed the same way, which proves they left the condition untouched.

// File: rtl/ep_tok_pkg.sv
package ep_tok_pkg;
    localparam int unsigned TOK_W  = 3;
    localparam int unsigned RESP_W = 3;

    localparam logic [TOK_W-1:0] TK_SETUP = 3'd0;
    localparam logic [TOK_W-1:0] TK_PING  = 3'd1;
    localparam logic [TOK_W-1:0] TK_OUT   = 3'd2;
    localparam logic [TOK_W-1:0] TK_IN    = 3'd3;
    localparam logic [TOK_W-1:0] TK_LAST  = TK_IN;

    typedef enum logic [2:0] {
        COND_IDLE     = 3'd0,
        COND_PRIMED   = 3'd1,
        COND_UNDERRUN = 3'd2,
        COND_OVERRUN  = 3'd3,
        COND_HALTED   = 3'd4
    } cond_e;

    typedef enum logic [RESP_W-1:0] {
        RSP_IGNORE  = 3'd0,
        RSP_STALL   = 3'd1,
        RSP_NAK     = 3'd2,
        RSP_ACK     = 3'd3,
        RSP_RX_ACK  = 3'd4,
        RSP_RX_NYET = 3'd5,
        RSP_TX      = 3'd6,
        RSP_BSERR   = 3'd7
    } resp_e;
endpackage

// File: rtl/ep_cond_fsm.sv
module ep_cond_fsm
    import ep_tok_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             prime_i,
    input  logic             stall_i,
    input  logic             unstall_i,
    input  logic             underflow_i,
    input  logic             overflow_i,
    input  logic             tok_valid_i,
    input  logic [TOK_W-1:0] tok_kind_i,
    input  logic             pkts_left_i,
    output cond_e            cond_o
);
    cond_e cond_q, cond_d;

    logic tok_in, tok_out;
    assign tok_in  = tok_valid_i && (tok_kind_i == TK_IN);
    assign tok_out = tok_valid_i && (tok_kind_i == TK_OUT);

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) cond_q <= COND_IDLE;
        else         cond_q <= cond_d;
    end

    // transitions
    always_comb begin
        cond_d = cond_q;
        if (stall_i) begin
            cond_d = COND_HALTED;                      // halt
        end else begin
            unique case (cond_q)
                COND_HALTED:   if (unstall_i) cond_d = COND_IDLE;        // release
                COND_IDLE:     if (prime_i)   cond_d = COND_PRIMED;      // arm
                COND_PRIMED: begin
                    if ((tok_in || tok_out) && !pkts_left_i)
                        cond_d = COND_IDLE;                              // finish
                    else if (underflow_i)
                        cond_d = COND_UNDERRUN;                          // starve
                    else if (overflow_i)
                        cond_d = COND_OVERRUN;                           // flood
                end
                COND_UNDERRUN: if (tok_in)  cond_d = COND_PRIMED;        // report-starve
                COND_OVERRUN:  if (tok_out) cond_d = COND_PRIMED;        // report-flood
                default:       cond_d = COND_IDLE;
            endcase
        end
    end

    assign cond_o = cond_q;
endmodule

// File: rtl/ep_resp_lut.sv
module ep_resp_lut
    import ep_tok_pkg::*;
(
    input  cond_e            cond_i,
    input  logic [TOK_W-1:0] tok_kind_i,
    input  logic             pkts_left_i,
    output resp_e            resp_o
);
    always_comb begin
        resp_o = RSP_IGNORE;
        if (tok_kind_i != TK_SETUP && tok_kind_i <= TK_LAST) begin
            unique case (cond_i)
                COND_HALTED:   resp_o = RSP_STALL;
                COND_IDLE:     resp_o = RSP_NAK;
                COND_PRIMED: begin
                    if (tok_kind_i == TK_PING)     resp_o = RSP_ACK;
                    else if (tok_kind_i == TK_IN)  resp_o = RSP_TX;
                    else                           resp_o = pkts_left_i ? RSP_RX_ACK : RSP_RX_NYET;
                end
                COND_UNDERRUN: resp_o = (tok_kind_i == TK_IN) ? RSP_BSERR : RSP_NAK;
                COND_OVERRUN:  resp_o = RSP_NAK;
                default:       resp_o = RSP_IGNORE;
            endcase
        end
    end
endmodule

// File: rtl/ep_token_responder.sv
module ep_token_responder
    import ep_tok_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              prime_i,
    input  logic              stall_i,
    input  logic              unstall_i,
    input  logic              underflow_i,
    input  logic              overflow_i,
    input  logic              tok_valid_i,
    input  logic [TOK_W-1:0]  tok_kind_i,
    input  logic              pkts_left_i,
    output logic              resp_valid_o,
    output logic [RESP_W-1:0] resp_code_o
);
    cond_e cond_q;
    resp_e resp_next;

    ep_cond_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .prime_i     (prime_i),
        .stall_i     (stall_i),
        .unstall_i   (unstall_i),
        .underflow_i (underflow_i),
        .overflow_i  (overflow_i),
        .tok_valid_i (tok_valid_i),
        .tok_kind_i  (tok_kind_i),
        .pkts_left_i (pkts_left_i),
        .cond_o      (cond_q)
    );

    ep_resp_lut u_lut (
        .cond_i      (cond_q),
        .tok_kind_i  (tok_kind_i),
        .pkts_left_i (pkts_left_i),
        .resp_o      (resp_next)
    );

    // output register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            resp_valid_o <= 1'b0;
            resp_code_o  <= RSP_IGNORE;
        end else begin
            resp_valid_o <= tok_valid_i;
            resp_code_o  <= tok_valid_i ? resp_next : RSP_IGNORE;
        end
    end
endmodule

// File: rtl/ep_token_responder_chk.sv
module ep_token_responder_chk
    import ep_tok_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              stall_i,
    input logic              unstall_i,
    input logic              tok_valid_i,
    input logic [TOK_W-1:0]  tok_kind_i,
    input logic              pkts_left_i,
    input cond_e             cond_i,
    input logic              resp_valid_o,
    input logic [RESP_W-1:0] resp_code_o
);
    logic answerable;
    assign answerable = tok_valid_i && tok_kind_i != TK_SETUP && tok_kind_i <= TK_LAST;

    AST_VALID_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tok_valid_i |=> resp_valid_o);                                          // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tok_valid_i |=> !resp_valid_o);                                        // R10
    AST_SETUP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tok_valid_i && tok_kind_i == TK_SETUP) |=> resp_code_o == RSP_IGNORE); // R2
    AST_INVALID_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tok_valid_i && tok_kind_i > TK_LAST) |=> resp_code_o == RSP_IGNORE);   // R3
    AST_HALT_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == COND_HALTED && answerable) |=> resp_code_o == RSP_STALL);    // R1
    AST_IDLE_NAKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == COND_IDLE && answerable) |=> resp_code_o == RSP_NAK);        // R4
    AST_NYET_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == COND_PRIMED && tok_valid_i && tok_kind_i == TK_OUT && !pkts_left_i)
        |=> resp_code_o == RSP_RX_NYET);                                        // R6
    AST_STALL_ENTERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_i |=> cond_i == COND_HALTED);                                     // R9
    AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == COND_HALTED && !unstall_i) |=> cond_i == COND_HALTED);       // R9
    AST_UNDERRUN_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == COND_UNDERRUN && tok_valid_i && tok_kind_i == TK_IN && !stall_i)
        |=> cond_i == COND_PRIMED);                                             // R7
    AST_OVERRUN_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == COND_OVERRUN && tok_valid_i && tok_kind_i == TK_OUT && !stall_i)
        |=> cond_i == COND_PRIMED);                                             // R8
endmodule

bind ep_token_responder ep_token_responder_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_i      (stall_i),
    .unstall_i    (unstall_i),
    .tok_valid_i  (tok_valid_i),
    .tok_kind_i   (tok_kind_i),
    .pkts_left_i  (pkts_left_i),
    .cond_i       (cond_q),
    .resp_valid_o (resp_valid_o),
    .resp_code_o  (resp_code_o)
);

// File: tb/sim_ep_token_responder.sv
`timescale 1ns/1ps
module sim_ep_token_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prime = 1'b0, stall = 1'b0, unstall = 1'b0, uflow = 1'b0, oflow = 1'b0;
    logic       tvalid = 1'b0, pkts = 1'b0;
    logic [2:0] tkind = 3'd0;
    logic       rvalid;
    logic [2:0] rcode;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ep_token_responder u0 (
        .clk_i(clk), .rst_ni(rst_n), .prime_i(prime), .stall_i(stall),
        .unstall_i(unstall), .underflow_i(uflow), .overflow_i(oflow),
        .tok_valid_i(tvalid), .tok_kind_i(tkind), .pkts_left_i(pkts),
        .resp_valid_o(rvalid), .resp_code_o(rcode)
    );

    // codes: kind 0 SETUP 1 PING 2 OUT 3 IN; resp 0 IGN 1 STALL 2 NAK 3 ACK 4 RXACK 5 RXNYET 6 TX 7 BSERR
    // prep: 0 idle, 1 primed, 2 underrun, 3 overrun, 4 halted
    typedef struct packed {
        logic [2:0] prep;
        logic [2:0] kind;
        logic       pk;
        logic [2:0] exp;
        logic [2:0] fkind;
        logic [2:0] fexp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 3'd1, 1'b1, 3'd2, 3'd3, 3'd2, 4'd4},  // R4 idle PING
        '{3'd0, 3'd2, 1'b1, 3'd2, 3'd3, 3'd2, 4'd4},  // R4 idle OUT
        '{3'd0, 3'd3, 1'b1, 3'd2, 3'd3, 3'd2, 4'd4},  // R4 idle IN
        '{3'd0, 3'd0, 1'b1, 3'd0, 3'd3, 3'd2, 4'd2},  // R2 idle SETUP
        '{3'd1, 3'd0, 1'b1, 3'd0, 3'd3, 3'd6, 4'd2},  // R2 primed SETUP
        '{3'd1, 3'd1, 1'b1, 3'd3, 3'd3, 3'd6, 4'd5},  // R5 primed PING
        '{3'd1, 3'd2, 1'b1, 3'd4, 3'd3, 3'd6, 4'd5},  // R5 primed OUT, more left
        '{3'd1, 3'd2, 1'b0, 3'd5, 3'd3, 3'd2, 4'd6},  // R6 primed OUT, last
        '{3'd1, 3'd3, 1'b1, 3'd6, 3'd3, 3'd6, 4'd5},  // R5 primed IN, more left
        '{3'd1, 3'd3, 1'b0, 3'd6, 3'd3, 3'd2, 4'd6},  // R6 primed IN, last
        '{3'd2, 3'd3, 1'b1, 3'd7, 3'd3, 3'd6, 4'd7},  // R7 underrun IN
        '{3'd2, 3'd2, 1'b1, 3'd2, 3'd3, 3'd7, 4'd7},  // R7 underrun OUT
        '{3'd2, 3'd1, 1'b1, 3'd2, 3'd3, 3'd7, 4'd7},  // R7 underrun PING
        '{3'd3, 3'd2, 1'b1, 3'd2, 3'd2, 3'd4, 4'd8},  // R8 overrun OUT
        '{3'd3, 3'd3, 1'b1, 3'd2, 3'd2, 3'd2, 4'd8},  // R8 overrun IN
        '{3'd3, 3'd1, 1'b1, 3'd2, 3'd2, 3'd2, 4'd8},  // R8 overrun PING
        '{3'd4, 3'd1, 1'b1, 3'd1, 3'd3, 3'd1, 4'd1},  // R1 halted PING
        '{3'd4, 3'd2, 1'b1, 3'd1, 3'd3, 3'd1, 4'd1},  // R1 halted OUT
        '{3'd4, 3'd3, 1'b1, 3'd1, 3'd3, 3'd1, 4'd1},  // R1 halted IN
        '{3'd4, 3'd0, 1'b1, 3'd0, 3'd3, 3'd1, 4'd2},  // R2 halted SETUP
        '{3'd1, 3'd5, 1'b1, 3'd0, 3'd3, 3'd6, 4'd3},  // R3 primed kind 5
        '{3'd4, 3'd7, 1'b1, 3'd0, 3'd3, 3'd1, 4'd3},  // R3 halted kind 7
        '{3'd2, 3'd4, 1'b1, 3'd0, 3'd3, 3'd7, 4'd3}   // R3 underrun kind 4
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {prime, stall, unstall, uflow, oflow, tvalid} = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // order: prime, stall, unstall, underflow, overflow
    task automatic ev(input logic p, input logic s, input logic u, input logic uf, input logic of);
        @(negedge clk);
        prime = p; stall = s; unstall = u; uflow = uf; oflow = of;
        @(negedge clk);
        {prime, stall, unstall, uflow, oflow} = '0;
    endtask

    task automatic tok(input logic [2:0] k, input logic pk, output logic [2:0] code, output logic v);
        @(negedge clk);
        tvalid = 1'b1; tkind = k; pkts = pk;
        @(negedge clk);
        tvalid = 1'b0;
        code = rcode; v = rvalid;
    endtask

    task automatic prep(input logic [2:0] p);
        do_reset();
        if (p != 3'd0) ev(1, 0, 0, 0, 0);
        if (p == 3'd2) ev(0, 0, 0, 1, 0);
        if (p == 3'd3) ev(0, 0, 0, 0, 1);
        if (p == 3'd4) ev(0, 1, 0, 0, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] c;
        logic v;

        // reset state, R10
        do_reset();
        @(negedge clk);
        check("R10", "resp_valid after reset", int'(rvalid), 0);
        tok(3'd3, 1'b1, c, v);
        check("R10", "resp_valid after token", int'(v), 1);
        check("R10", "reset condition is idle (IN->NAK)", int'(c), 2);
        @(negedge clk);
        check("R10", "resp_valid drops without token", int'(rvalid), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].req);
            prep(VEC[i].prep);
            tok(VEC[i].kind, VEC[i].pk, c, v);
            check(rq, $sformatf("vec %0d response", i), int'(c), int'(VEC[i].exp));
            tok(VEC[i].fkind, 1'b1, c, v);
            check(rq, $sformatf("vec %0d follow-up", i), int'(c), int'(VEC[i].fexp));
        end

        // R9: stall and unstall together -> halted
        prep(3'd1);
        ev(0, 1, 1, 0, 0);
        tok(3'd3, 1'b1, c, v);
        check("R9", "stall beats unstall", int'(c), 1);
        // R9: unstall -> idle, prime rearms
        ev(0, 0, 1, 0, 0);
        tok(3'd3, 1'b1, c, v);
        check("R9", "unstall returns to idle", int'(c), 2);
        ev(1, 0, 0, 0, 0);
        tok(3'd3, 1'b1, c, v);
        check("R9", "prime after unstall", int'(c), 6);
        // R9: stall from underrun
        prep(3'd2);
        ev(0, 1, 0, 0, 0);
        tok(3'd3, 1'b1, c, v);
        check("R9", "stall from underrun", int'(c), 1);
        // R9: stall from idle
        prep(3'd0);
        ev(0, 1, 0, 0, 0);
        tok(3'd1, 1'b1, c, v);
        check("R9", "stall from idle", int'(c), 1);

        // R11: underflow/overflow in idle have no effect
        prep(3'd0);
        ev(0, 0, 0, 1, 1);
        ev(1, 0, 0, 0, 0);
        tok(3'd3, 1'b1, c, v);
        check("R11", "underflow in idle ignored", int'(c), 6);
        // R11: prime in halted has no effect
        prep(3'd4);
        ev(1, 0, 0, 0, 0);
        tok(3'd3, 1'b1, c, v);
        check("R11", "prime while halted ignored", int'(c), 1);
        // R11: overflow in underrun has no effect
        prep(3'd2);
        ev(0, 0, 0, 0, 1);
        tok(3'd3, 1'b1, c, v);
        check("R11", "overflow in underrun ignored", int'(c), 7);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule